// File: doc/BRIEF.md
# UART Register Window

This block is an APB slave that presents a small UART register window to software while leaving the line side to other logic. Bytes from a receiver arrive on a valid/byte input and collect in a receive store. Software takes them out, oldest first, by reading the data register. A write to the data register sends the low byte out on a valid/byte transmit output, but only while transmit is enabled. The block has no baud generator, serial shifter, parity logic or flow control. The control bits for those functions are stored and read back. The matching status bits read as constants: the transmit path always reports empty, and the error and level bits report zero.

A three-state bus sequencer tracks the APB handshake. BUS_IDLE moves to BUS_SETUP when select is high and enable is low. BUS_SETUP moves to BUS_ACCESS when enable rises with select held high, stays in BUS_SETUP while enable stays low, and returns to BUS_IDLE if select drops. BUS_ACCESS returns to BUS_IDLE, or goes straight back to BUS_SETUP when a new transfer is already selected. The register action, meaning a store or a pop, happens only on the clock edge that ends the setup-to-access transition. Each access therefore completes in one access cycle.

The receive store keeps a write slot counter and a read pointer. Both go back to zero on the read that takes the last unread byte. Slots that have been read are not reused before that point. A single interrupt line gives a one-cycle pulse for each accepted byte when receive interrupts are enabled, and for each emitted byte when transmit interrupts are enabled.

Top module: `uart_reg_window`

## Requirements
- R1: Only paddr[7:0] is decoded. Offset 0x00 selects data, 0x04 status, 0x08 control and 0x0C scaler. Every other offset reads as zero and ignores writes. Address bits above bit 7 have no effect.
- R2: Offset 0x03 behaves exactly like offset 0x00 for both reads and writes, with the byte in bits 7:0.
- R3: An input byte is stored only while control bit 0 (receive enable) is 1 and rx_ready is high. rx_ready is low exactly when DEPTH slots have been written since the store last emptied. Reading a byte without emptying the store frees no slot. A byte offered while rx_ready is high and receive is disabled is dropped.
- R4: Reading data returns stored bytes in arrival order. Each byte is removed by exactly one access-cycle read.
- R5: Status bit 0 (data ready) is 1 exactly while unread bytes remain. It clears on the read that empties the store.
- R6: Reading data while the store is empty returns zero.
- R7: A data write while control bit 1 (transmit enable) is 1 raises tx_valid for one cycle, in the cycle after the access, with tx_byte equal to pwdata[7:0]. While the bit is 0, the write emits nothing.
- R8: irq pulses high for one cycle after each stored byte when control bit 2 is 1, and after each emitted byte when control bit 3 is 1. It pulses at no other time.
- R9: Control stores and returns all 32 written bits. Status ignores writes. The scaler always reads as zero.
- R10: After reset, control reads 0, the store is empty, and status reads 0x00000006 (bit 1 transmit shift empty, bit 2 transmit holding empty).
- R11: pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB address; only bits 7:0 decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access cycle |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Store has a free slot |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Receive traffic is driven with the store filled to capacity and one byte beyond it. It is then drained through both data aliases and through an aliased upper address, which separates the ordering, the delayed slot release and the data-ready flag from one another. Random mixes of pushes, pops, data writes and control rewrites shift the enable and interrupt bits between events. Each emitted byte and each interrupt pulse is thereby attributed to the control value in force at that moment. Extra reads on an empty store and data writes with transmit disabled separate the zero-return and no-emission cases from normal operation.

// File: rtl/uart_win_pkg.sv
package uart_win_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_SETUP  = 2'd1,
        BUS_ACCESS = 2'd2
    } bus_state_t;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_STAT  = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_SCALE = 3'd4
    } reg_sel_t;

    localparam logic [7:0] OFS_DATA    = 8'h00;
    localparam logic [7:0] OFS_DATA_B3 = 8'h03;
    localparam logic [7:0] OFS_STAT    = 8'h04;
    localparam logic [7:0] OFS_CTRL    = 8'h08;
    localparam logic [7:0] OFS_SCALE   = 8'h0C;

    // control bits used by the block
    localparam int CT_RXEN = 0;
    localparam int CT_TXEN = 1;
    localparam int CT_RXIE = 2;
    localparam int CT_TXIE = 3;

    // status bits driven by the block
    localparam int ST_READY  = 0;
    localparam int ST_TSHIFT = 1;
    localparam int ST_THOLD  = 2;

    function automatic reg_sel_t decode_ofs(input logic [7:0] ofs);
        reg_sel_t s;
        case (ofs)
            OFS_DATA, OFS_DATA_B3: s = SEL_DATA;
            OFS_STAT:              s = SEL_STAT;
            OFS_CTRL:              s = SEL_CTRL;
            OFS_SCALE:             s = SEL_SCALE;
            default:               s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/uart_win_bus.sv
module uart_win_bus
    import uart_win_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic rd_stb,
    output logic wr_stb
);

    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   state_d = (psel && !penable) ? BUS_SETUP : BUS_IDLE;
            BUS_SETUP: begin
                if (psel && penable) state_d = BUS_ACCESS;
                else if (psel)       state_d = BUS_SETUP;
                else                 state_d = BUS_IDLE;
            end
            BUS_ACCESS: state_d = (psel && !penable) ? BUS_SETUP : BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    // action strobes: only on the setup-to-access transition
    always_comb begin
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        if (state_q == BUS_SETUP && psel && penable) begin
            rd_stb = !pwrite;
            wr_stb = pwrite;
        end
    end

endmodule

// File: rtl/uart_win_rxbuf.sv
module uart_win_rxbuf #(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [7:0]                   push_byte,
    input  logic                         pop,
    output logic [7:0]                   pop_byte,
    output logic                         drained,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   used,
    output logic [$clog2(DEPTH+1)-1:0]   unread
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] len_q, rd_q, len_d, rd_d;
    logic [AW-1:0] wr_addr;
    logic          has_data, do_pop;

    assign has_data = (len_q != '0);
    assign do_pop   = pop && has_data;
    assign drained  = do_pop && ((rd_q + CW'(1)) == len_q);
    assign full     = (len_q == CW'(DEPTH));
    assign used     = len_q;
    assign unread   = len_q - rd_q;

    // a drain and a push in the same cycle restart the store at slot 0
    assign wr_addr  = drained ? '0 : len_q[AW-1:0];
    assign len_d    = drained ? CW'(push) : len_q + CW'(push);
    assign rd_d     = drained ? '0 : rd_q + CW'(do_pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            rd_q  <= '0;
        end else begin
            len_q <= len_d;
            rd_q  <= rd_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_addr] <= push_byte;
    end

    assign pop_byte = has_data ? mem[rd_q[AW-1:0]] : 8'h00;

endmodule

// File: rtl/uart_win_evt.sv
module uart_win_evt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_take,
    input  logic       rx_ie,
    input  logic       tx_go,
    input  logic       tx_ie,
    input  logic [7:0] tx_din,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= 8'h00;
            irq      <= 1'b0;
        end else begin
            tx_valid <= tx_go;
            if (tx_go) tx_byte <= tx_din;
            irq <= (rx_take && rx_ie) || (tx_go && tx_ie);
        end
    end

endmodule

// File: rtl/uart_reg_window.sv
module uart_reg_window
    import uart_win_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              irq
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          rd_stb, wr_stb;
    reg_sel_t      sel;
    logic [31:0]   ctrl_q;
    logic          rdy_q;
    logic          rx_take, pop, tx_go, drained, rx_full;
    logic [7:0]    pop_byte;
    logic [CW-1:0] rx_used, rx_unread;
    logic [31:0]   status;
    logic          unused_hi;

    assign unused_hi = ^paddr[ADDR_W-1:8];
    assign pready    = 1'b1;
    assign pslverr   = 1'b0;

    uart_win_bus u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb)
    );

    assign sel      = decode_ofs(paddr[7:0]);
    assign rx_ready = !rx_full;
    assign rx_take  = rx_valid && rx_ready && ctrl_q[CT_RXEN];
    assign pop      = rd_stb && (sel == SEL_DATA);
    assign tx_go    = wr_stb && (sel == SEL_DATA) && ctrl_q[CT_TXEN];

    uart_win_rxbuf #(.DEPTH(DEPTH)) u_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_take),
        .push_byte (rx_byte),
        .pop       (pop),
        .pop_byte  (pop_byte),
        .drained   (drained),
        .full      (rx_full),
        .used      (rx_used),
        .unread    (rx_unread)
    );

    uart_win_evt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_take  (rx_take),
        .rx_ie    (ctrl_q[CT_RXIE]),
        .tx_go    (tx_go),
        .tx_ie    (ctrl_q[CT_TXIE]),
        .tx_din   (pwdata[7:0]),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .irq      (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 32'h0;
        end else if (wr_stb && sel == SEL_CTRL) begin
            ctrl_q <= pwdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
        end else if (rx_take) begin
            rdy_q <= 1'b1;
        end else if (pop && (drained || rx_unread == '0)) begin
            rdy_q <= 1'b0;
        end
    end

    always_comb begin
        status            = 32'h0;
        status[ST_READY]  = rdy_q;
        status[ST_TSHIFT] = 1'b1;
        status[ST_THOLD]  = 1'b1;
    end

    always_comb begin
        prdata = 32'h0;
        if (rd_stb) begin
            case (sel)
                SEL_DATA: prdata = {24'h0, pop_byte};
                SEL_STAT: prdata = status;
                SEL_CTRL: prdata = ctrl_q;
                default:  prdata = 32'h0;
            endcase
        end
    end

endmodule

// File: rtl/uart_win_checks.sv
module uart_win_checks #(
    parameter int DEPTH = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        psel,
    input logic                        penable,
    input logic                        pwrite,
    input logic                        pready,
    input logic                        pslverr,
    input logic                        rx_valid,
    input logic                        rx_ready,
    input logic                        tx_valid,
    input logic                        irq,
    input logic [31:0]                 ctrl_q,
    input logic                        rdy_q,
    input logic [$clog2(DEPTH+1)-1:0]  rx_used,
    input logic [$clog2(DEPTH+1)-1:0]  rx_unread
);

    a_r11_bus_resp: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_used <= ($clog2(DEPTH+1))'(DEPTH));

    a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |=> rx_used <= $past(rx_used));

    a_r5_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q == (rx_unread != '0));

    a_r4_pop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_unread < $past(rx_unread)) |-> $past(psel && penable && !pwrite));

    a_r7_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    a_r7_tx_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(ctrl_q[1] && psel && penable && pwrite));

    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(rx_valid && rx_ready && ctrl_q[0] && ctrl_q[2])
                 || (tx_valid && $past(ctrl_q[3]))));

endmodule

bind uart_reg_window uart_win_checks #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_reg_window_bench.sv
module uart_reg_window_bench;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_byte;

    always #2 clk = ~clk;

    uart_reg_window #(.DEPTH(DEPTH), .ADDR_W(12)) u_uart_reg_window (.*);

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // reference model
    byte unsigned mq[$];
    byte unsigned txq[$];
    int           slots = 0;
    logic [31:0]  mctrl = 32'h0;
    int           exp_irq = 0, got_irq = 0, exp_tx = 0, got_tx = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return 32'h6 | ((mq.size() != 0) ? 32'h1 : 32'h0);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) got_irq++;
            if (tx_valid) begin
                got_tx++;
                if (txq.size() == 0) check(0, "R7", "unexpected tx", {24'h0, tx_byte}, 32'h0);
                else begin
                    byte unsigned e;
                    e = txq.pop_front();
                    check(tx_byte === e, "R7", "tx byte", {24'h0, tx_byte}, {24'h0, e});
                end
            end
        end
    end

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1;
        d = prdata;
        check(pready === 1'b1 && pslverr === 1'b0, "R11", "bus response",
              {30'h0, pready, pslverr}, 32'h2);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = v;
        @(negedge clk); penable = 1; #1;
        check(pready === 1'b1 && pslverr === 1'b0, "R11", "bus response",
              {30'h0, pready, pslverr}, 32'h2);
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rx_send(input byte unsigned b);
        @(negedge clk); rx_valid = 1; rx_byte = b; #1;
        check(rx_ready === (slots < DEPTH), "R3", "rx_ready", {31'h0, rx_ready},
              {31'h0, slots < DEPTH});
        if (slots < DEPTH && mctrl[0]) begin
            mq.push_back(b);
            slots++;
            if (mctrl[2]) exp_irq++;
        end
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic rd_data(input logic [11:0] a, input string req);
        logic [31:0] d, e;
        apb_rd(a, d);
        if (mq.size() > 0) begin
            e = {24'h0, mq.pop_front()};
            if (mq.size() == 0) slots = 0;
        end else e = 32'h0;
        check(d === e, req, "data read", d, e);
    endtask

    task automatic wr_data(input logic [11:0] a, input logic [31:0] v);
        apb_wr(a, v);
        if (mctrl[1]) begin
            txq.push_back(v[7:0]);
            exp_tx++;
            if (mctrl[3]) exp_irq++;
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        apb_wr(12'h008, v);
        mctrl = v;
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [31:0] e, input string req,
                            input string what);
        logic [31:0] d;
        apb_rd(a, d);
        check(d === e, req, what, d, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd200000, 32'd0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int irq0;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state
        check(rx_ready === 1'b1, "R10", "rx_ready after reset", {31'h0, rx_ready}, 32'h1);
        rd_check(12'h004, 32'h6, "R10", "status after reset");
        rd_check(12'h008, 32'h0, "R10", "control after reset");
        rd_data(12'h000, "R6");
        rd_check(12'h004, 32'h6, "R6", "status after empty read");

        // receive disabled: byte dropped
        rx_send(8'h5A);
        rd_check(12'h004, 32'h6, "R3", "status after disabled rx");

        // register map
        wr_ctrl(32'hFFFF_FFF0);
        rd_check(12'h008, 32'hFFFF_FFF0, "R9", "control full word");
        rd_check(12'h108, 32'hFFFF_FFF0, "R1", "control via high alias");
        apb_wr(12'h004, 32'hFFFF_FFFF);
        rd_check(12'h004, 32'h6, "R9", "status ignores write");
        apb_wr(12'h00C, 32'h1234_5678);
        rd_check(12'h00C, 32'h0, "R9", "scaler reads zero");
        apb_wr(12'h010, 32'hDEAD_BEEF);
        rd_check(12'h010, 32'h0, "R1", "unknown offset");
        rd_check(12'h008, 32'hFFFF_FFF0, "R1", "control after unknown write");

        // fill beyond capacity with receive interrupt enabled
        wr_ctrl(32'h0000_0005);
        irq0 = got_irq;
        for (int i = 0; i <= DEPTH; i++) rx_send(8'h10 + 8'(i));
        @(negedge clk);
        check(got_irq - irq0 == DEPTH, "R8", "rx irq pulses", got_irq - irq0, DEPTH);
        check(rx_ready === 1'b0, "R3", "rx_ready when full", {31'h0, rx_ready}, 32'h0);
        rd_check(12'h004, 32'h7, "R5", "status with data");

        // drain through aliases
        rd_data(12'h003, "R2");
        check(rx_ready === 1'b0, "R3", "no slot freed by partial read", {31'h0, rx_ready}, 32'h0);
        rx_send(8'hEE);
        rd_data(12'h100, "R1");
        for (int i = 2; i < DEPTH; i++) rd_data(12'h000, "R4");
        rd_check(12'h004, 32'h6, "R5", "status after drain");
        check(rx_ready === 1'b1, "R3", "rx_ready after drain", {31'h0, rx_ready}, 32'h1);
        rd_data(12'h000, "R6");

        // transmit disabled then enabled
        wr_ctrl(32'h0000_0001);
        irq0 = got_irq;
        wr_data(12'h000, 32'h0000_0077);
        @(negedge clk);
        check(got_tx == 0, "R7", "no tx when disabled", got_tx, 0);
        wr_ctrl(32'h0000_000A);
        wr_data(12'h000, 32'h1234_56AB);
        @(negedge clk);
        check(got_tx == 1, "R7", "tx when enabled", got_tx, 1);
        check(got_irq - irq0 == 1, "R8", "tx irq pulse", got_irq - irq0, 1);
        wr_data(12'h003, 32'h0000_00C3);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) rx_send(8'($urandom));
            else if (op < 5) rd_data(($urandom_range(0, 1) != 0) ? 12'h003 : 12'h000, "R4");
            else if (op < 7) wr_data(12'h000, $urandom);
            else if (op < 9) rd_check(12'h004, exp_status(), "R5", "status random");
            else wr_ctrl({$urandom_range(0, 255), 4'($urandom_range(0, 15)) | 4'h1});
        end

        repeat (4) @(negedge clk);
        check(got_tx == exp_tx, "R7", "total tx count", got_tx, exp_tx);
        check(got_irq == exp_irq, "R8", "total irq count", got_irq, exp_irq);
        check(txq.size() == 0, "R7", "pending tx", txq.size(), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule